// File: doc/BRIEF.md
# Serial Port Expander Writer

This block keeps a bank of external serial-in, parallel-out latching shift registers up to date from inside the chip. A client hands it a 16-bit output word over a valid/ready stream. The block pulls the storage-latch clock low, shifts the word out on a write-only serial link and then raises the latch clock. That rising edge moves the new pattern onto the expander's parallel pins.

The serial link uses clock-idle-high timing. Data moves on each falling edge and the expander samples it on each rising edge. The word leaves as two bytes, the low byte first, and each byte goes least-significant bit first. The serial clock is derived from the system clock by a divider that a parameter sets.

After reset the expander outputs stay disabled through an active-low enable. The block first sends a fixed power-up word of its own, which a parameter sets. It enables the outputs only once that word has been latched.

Back-pressure rules for the input stream: `wr_ready` is high only when no transfer is in flight and the power-up word has already gone out. A word is taken on a clock edge where both `wr_valid` and `wr_ready` are high. While `wr_ready` is low, the source keeps `wr_valid` high and may replace `wr_data` freely. The word present at the accepting edge is the one sent, so the most recent value wins.

Top module: `spx_expander`

## Requirements
- R1: Serial bit k of a frame (k = 0 first) equals bit k of the word. So bits 7..0 go out first, LSB first, then bits 15..8, LSB first.
- R2: `sclk` idles high. `sdo` changes only in the cycle where `sclk` falls. Every low phase of `sclk` lasts exactly HALF_DIV system clocks.
- R3: `rclk` falls before the first falling edge of `sclk` in a frame. Exactly 16 rising `sclk` edges occur while `rclk` is low, and `rclk` stays low until all of them have occurred.
- R4: When `rclk` rises, `sclk` has been high for at least HALF_DIV system clocks.
- R5: During reset, `sclk`, `rclk` and `oe_n` are 1, and `busy` and `wr_ready` are 0.
- R6: After reset the block sends INIT_WORD without any request. `oe_n` stays 1 until the rising `rclk` edge that ends that frame, and stays 0 from then on.
- R7: `wr_ready` is low while `busy` is high or the power-up word is still pending. After an accepting edge, `busy` and a low `rclk` follow at once. `busy` falls on the same edge where `rclk` rises.
- R8: A request held valid while the block is busy is sent once the block is free. If `wr_data` changes while the request waits, the value present at the accepting edge is the one sent.
- R9: Between the last rising `sclk` edge of the low byte and the first falling edge of the high byte, `sclk` stays high for at least HALF_DIV system clocks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_valid | input | 1 | A word is offered on wr_data |
| wr_ready | output | 1 | Block will accept the offered word on this edge |
| wr_data | input | 16 | Output word for the expander |
| busy | output | 1 | A frame is in progress (latch clock low) |
| sclk | output | 1 | Serial clock, idles high |
| sdo | output | 1 | Serial data, changes on falling sclk |
| rclk | output | 1 | Storage-latch clock, rising edge updates expander pins |
| oe_n | output | 1 | Active-low expander output enable |

## Verification
The hardest case to reach from the ports is a request that arrives while a frame is already in flight, with its data changing during the wait. The stimulus reaches this with a request issued right after reset, while the power-up word is still shifting. It also uses random back-to-back requests, each with a random chance of rewriting `wr_data` every waiting cycle. A port monitor rebuilds every frame from the serial pins and compares it with the word seen at the accepting edge. It also times the low phases, the gap between the two bytes and the tail before the latch edge.

// File: rtl/spx_pkg.sv
package spx_pkg;
  typedef enum logic [1:0] {
    SQ_IDLE  = 2'd0,
    SQ_SETUP = 2'd1,
    SQ_BYTE  = 2'd2,
    SQ_TAIL  = 2'd3
  } spx_state_e;
endpackage

// File: rtl/spx_clkdiv.sv
// Half-period tick generator for the serial clock; restarts when idle.
module spx_clkdiv #(
  parameter int HALF_DIV = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (!run || cnt == LAST) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  assign tick = run && (cnt == LAST);
endmodule

// File: rtl/spx_byte_tx.sv
// Shifts one byte out LSB first with clock idle high; data set on falling edge.
module spx_byte_tx #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              load,
  input  logic [BYTE_W-1:0] din,
  output logic              sclk,
  output logic              sdo,
  output logic              done
);
  localparam int CNT_W = (BYTE_W > 1) ? $clog2(BYTE_W) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(BYTE_W - 1);

  logic [BYTE_W-1:0] shreg;
  logic [CNT_W-1:0]  cnt;
  logic              active;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg  <= '0;
      cnt    <= '0;
      active <= 1'b0;
      sclk   <= 1'b1;
      sdo    <= 1'b0;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      if (load) begin
        shreg  <= din;
        cnt    <= '0;
        active <= 1'b1;
      end else if (active && tick) begin
        if (sclk) begin
          sclk <= 1'b0;
          sdo  <= shreg[0];
        end else begin
          sclk  <= 1'b1;
          shreg <= shreg >> 1;
          if (cnt == LAST) begin
            active <= 1'b0;
            done   <= 1'b1;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/spx_seq.sv
// Frame sequencer: latch-clock framing, byte ordering, power-up word, enable gating.
module spx_seq
  import spx_pkg::*;
#(
  parameter int                WORD_W    = 16,
  parameter int                BYTE_W    = 8,
  parameter logic [WORD_W-1:0] INIT_WORD = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [WORD_W-1:0] req_data,
  input  logic              tick,
  input  logic              tx_done,
  output logic              tx_load,
  output logic [BYTE_W-1:0] tx_byte,
  output logic              run,
  output logic              rclk,
  output logic              oe_n
);
  localparam int NBYTES = WORD_W / BYTE_W;
  localparam int BI_W   = (NBYTES > 1) ? $clog2(NBYTES) : 1;
  localparam logic [BI_W-1:0] LASTB = BI_W'(NBYTES - 1);

  spx_state_e        state;
  logic [WORD_W-1:0] word;
  logic [BI_W-1:0]   bidx;
  logic              init_pend;
  logic [BYTE_W-1:0] bytes [NBYTES];

  for (genvar g = 0; g < NBYTES; g++) begin : g_split
    assign bytes[g] = word[g*BYTE_W +: BYTE_W];
  end

  assign tx_byte   = bytes[bidx];
  assign run       = (state != SQ_IDLE);
  assign req_ready = (state == SQ_IDLE) && !init_pend;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= SQ_IDLE;
      word      <= '0;
      bidx      <= '0;
      init_pend <= 1'b1;
      rclk      <= 1'b1;
      oe_n      <= 1'b1;
      tx_load   <= 1'b0;
    end else begin
      tx_load <= 1'b0;
      unique case (state)
        SQ_IDLE: begin
          if (init_pend) begin
            word  <= INIT_WORD;
            rclk  <= 1'b0;
            state <= SQ_SETUP;
          end else if (req_valid) begin
            word  <= req_data;
            rclk  <= 1'b0;
            state <= SQ_SETUP;
          end
        end
        SQ_SETUP: begin
          if (tick) begin
            bidx    <= '0;
            tx_load <= 1'b1;
            state   <= SQ_BYTE;
          end
        end
        SQ_BYTE: begin
          if (tx_done) begin
            if (bidx == LASTB) begin
              state <= SQ_TAIL;
            end else begin
              bidx    <= bidx + 1'b1;
              tx_load <= 1'b1;
            end
          end
        end
        SQ_TAIL: begin
          if (tick) begin
            rclk  <= 1'b1;
            bidx  <= '0;
            state <= SQ_IDLE;
            if (init_pend) begin
              init_pend <= 1'b0;
              oe_n      <= 1'b0;
            end
          end
        end
        default: state <= SQ_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/spx_expander.sv
module spx_expander #(
  parameter int          HALF_DIV  = 2,
  parameter logic [15:0] INIT_WORD = 16'h03B8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_valid,
  output logic        wr_ready,
  input  logic [15:0] wr_data,
  output logic        busy,
  output logic        sclk,
  output logic        sdo,
  output logic        rclk,
  output logic        oe_n
);
  localparam int WORD_W = 16;
  localparam int BYTE_W = 8;

  logic              tick;
  logic              run;
  logic              tx_load;
  logic              tx_done;
  logic [BYTE_W-1:0] tx_byte;

  spx_clkdiv #(.HALF_DIV(HALF_DIV)) u_div (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (run),
    .tick (tick)
  );

  spx_seq #(
    .WORD_W   (WORD_W),
    .BYTE_W   (BYTE_W),
    .INIT_WORD(INIT_WORD)
  ) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_valid(wr_valid),
    .req_ready(wr_ready),
    .req_data (wr_data),
    .tick     (tick),
    .tx_done  (tx_done),
    .tx_load  (tx_load),
    .tx_byte  (tx_byte),
    .run      (run),
    .rclk     (rclk),
    .oe_n     (oe_n)
  );

  spx_byte_tx #(.BYTE_W(BYTE_W)) u_tx (
    .clk  (clk),
    .rst_n(rst_n),
    .tick (tick),
    .load (tx_load),
    .din  (tx_byte),
    .sclk (sclk),
    .sdo  (sdo),
    .done (tx_done)
  );

  assign busy = run;
endmodule

// File: rtl/spx_expander_chk.sv
module spx_expander_chk (
  input logic clk,
  input logic rst_n,
  input logic wr_valid,
  input logic wr_ready,
  input logic busy,
  input logic sclk,
  input logic sdo,
  input logic rclk,
  input logic oe_n
);
  p_sclk_idle_high_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> sclk);
  p_sdo_on_fall_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sdo) |-> $fell(sclk));
  p_rclk_low_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !rclk |-> busy);
  p_latch_clk_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rclk) |-> sclk);
  p_oe_after_latch_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(oe_n) |-> $rose(rclk));
  p_oe_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !oe_n |=> !oe_n);
  p_ready_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ready |-> !busy);
  p_accept_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_ready) |=> (busy && !rclk));
  p_busy_end_latch_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $rose(rclk));
endmodule

bind spx_expander spx_expander_chk u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .wr_valid(wr_valid),
  .wr_ready(wr_ready),
  .busy    (busy),
  .sclk    (sclk),
  .sdo     (sdo),
  .rclk    (rclk),
  .oe_n    (oe_n)
);

// File: tb/spx_expander_tb.sv
`timescale 1ns/1ps
module spx_expander_tb;
  localparam int          CLK_PERIOD = 10;
  localparam int          HALF_DIV   = 2;
  localparam logic [15:0] INIT_WORD  = 16'h03B8;
  localparam int          WD_LIMIT   = 150000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_valid = 1'b0;
  logic [15:0] wr_data = '0;
  logic        wr_ready, busy, sclk, sdo, rclk, oe_n;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  spx_expander #(.HALF_DIV(HALF_DIV), .INIT_WORD(INIT_WORD)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_data(wr_data), .busy(busy), .sclk(sclk), .sdo(sdo),
    .rclk(rclk), .oe_n(oe_n)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // Serial position k carries word bit k (low byte first, LSB first).
  function automatic logic exp_bit(input logic [15:0] w, input int k);
    return w[k];
  endfunction

  function automatic logic [15:0] expected_frame(input logic [15:0] w);
    logic [15:0] r;
    for (int k = 0; k < 16; k++) r[k] = exp_bit(w, k);
    return r;
  endfunction

  // ---------------- port monitor ----------------
  logic [15:0] exp_q[$];
  logic [15:0] cap;
  logic        p_sclk = 1'b1, p_rclk = 1'b1, p_sdo = 1'b0, p_oe = 1'b1;
  int          bitcnt = 0, lo_cnt = 0, hi_cnt = 0, frames = 0;
  bit          hs_pend = 1'b0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (sdo !== p_sdo)
        check(p_sclk && !sclk, "R2 sdo change off falling edge", {p_sclk, sclk}, 32'h2);
      if (p_rclk && !rclk) begin
        check(sclk === 1'b1, "R3 sclk high at latch fall", sclk, 1);
        bitcnt = 0;
      end
      if (p_sclk && !sclk) begin
        check(!rclk, "R3 sclk activity only inside frame", rclk, 0);
        if (bitcnt == 8)
          check(hi_cnt >= HALF_DIV, "R9 gap between bytes", hi_cnt, HALF_DIV);
      end
      if (!p_sclk && sclk) begin
        check(lo_cnt == HALF_DIV, "R2 low phase length", lo_cnt, HALF_DIV);
        if (!rclk && bitcnt < 16) cap[bitcnt] = sdo;
        bitcnt++;
      end
      if (!p_rclk && rclk) begin
        logic [15:0] e;
        check(bitcnt == 16, "R3 bits per frame", bitcnt, 16);
        check(sclk && hi_cnt >= HALF_DIV, "R4 tail before latch", hi_cnt, HALF_DIV);
        check(busy === 1'b0, "R7 busy ends with latch", busy, 0);
        if (exp_q.size() == 0) begin
          check(1'b0, "R1 unexpected frame", cap, 0);
        end else begin
          e = exp_q.pop_front();
          check(cap == expected_frame(e), frames == 0 ? "R6 power-up word" : "R1 frame data",
                cap, expected_frame(e));
        end
        check(oe_n === 1'b0, "R6 outputs enabled after latch", oe_n, 0);
        if (frames == 0)
          check(p_oe === 1'b1, "R6 outputs disabled before first latch", p_oe, 1);
        frames++;
      end
      if (frames == 0 && !(!p_rclk && rclk))
        check(oe_n === 1'b1, "R6 oe_n held before first latch", oe_n, 1);
      if (busy && wr_ready)
        check(1'b0, "R7 ready while busy", wr_ready, 0);
      if (hs_pend) begin
        check(busy && !rclk, "R7 busy after accept", {busy, rclk}, 32'h2);
        hs_pend = 1'b0;
      end
      if (wr_valid && wr_ready) begin
        exp_q.push_back(wr_data);
        hs_pend = 1'b1;
      end
      lo_cnt = sclk ? 0 : lo_cnt + 1;
      hi_cnt = sclk ? hi_cnt + 1 : 0;
      p_sclk = sclk; p_rclk = rclk; p_sdo = sdo; p_oe = oe_n;
    end
  end

  // ---------------- driver ----------------
  task automatic send(input logic [15:0] d, input bit churn);
    @(posedge clk); #1;
    wr_valid = 1'b1;
    wr_data  = d;
    @(negedge clk);
    while (!wr_ready) begin
      @(posedge clk); #1;
      if (churn) wr_data = 16'($urandom);
      @(negedge clk);
    end
    @(posedge clk); #1;
    wr_valid = 1'b0;
  endtask

  initial begin
    void'($urandom(32'd4711));
    exp_q.push_back(INIT_WORD);
    repeat (3) @(negedge clk);
    // R5 reset state
    check(sclk === 1'b1, "R5 sclk in reset", sclk, 1);
    check(rclk === 1'b1, "R5 rclk in reset", rclk, 1);
    check(oe_n === 1'b1, "R5 oe_n in reset", oe_n, 1);
    check(busy === 1'b0, "R5 busy in reset", busy, 0);
    check(wr_ready === 1'b0, "R5 ready in reset", wr_ready, 0);
    @(posedge clk); #1;
    rst_n = 1'b1;
    // R8: request during power-up frame with data churning while it waits
    send(16'hA5C3, 1'b1);
    send(16'h0000, 1'b0);
    send(16'hFFFF, 1'b0);
    send(16'h8001, 1'b0);
    send(16'h00FF, 1'b0);
    send(16'hFF00, 1'b1);
    for (int i = 0; i < 40; i++) begin
      repeat ($urandom_range(0, 6)) @(posedge clk);
      send(16'($urandom), 1'($urandom_range(0, 1)));
    end
    while (exp_q.size() != 0 || busy) @(negedge clk);
    repeat (4) @(negedge clk);
    check(rclk === 1'b1 && sclk === 1'b1, "R2 idle levels at end", {rclk, sclk}, 32'h3);
    check(frames == 47, "R8 every request sent once", frames, 47);
    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (WD_LIMIT) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog R7 actual=hang expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule